// File: doc/BRIEF.md
# Link Statistics Counter Bank

This block keeps five link-quality statistics for an Ethernet physical layer. Single-cycle event strobes arrive from the PCS/MAC side. They report a packet received without error, a receive CRC error, a transmitted packet, a receive error while data was flowing, and a receive error while the line was idle. The first three events feed 48-bit counters. The two receive-error events feed 16-bit counters. Every counter stops at its all-ones value and does not wrap.

A management agent reads the counters through 16-bit registers on a simple read port. The port takes a 5-bit address and a read strobe, and returns the data one cycle later. A 48-bit counter is read as three words. Reading the low word captures the middle and upper words into holding registers, so the three words always come from one instant. Reading the upper word last resets the counter, which makes each full read a self-clearing sample of the interval since the previous one. The 16-bit counters occupy one register each and also clear when read. When an event lands in the same cycle as a clearing read, the counter restarts at one, so no event is lost.

Top module: `link_stat_bank`

## Requirements
- R1: An event strobe that is high in a cycle raises its counter by one at that clock edge. Counter groups are selected by address bits [3:2]: 0 for received-good packets, 1 for CRC errors, 2 for transmitted packets. Bits [1:0] select the word: 0 low, 1 mid, 2 high.
- R2: A read of a low word (bits [1:0] = 0) returns bits 15:0 of the live counter as it stood before that cycle's event, if any.
- R3: A low-word read latches counter bits 31:16 and 47:32 into holding registers. Mid and high reads return those latched values, and later events do not change them.
- R4: A high-word read clears its 48-bit counter to zero. A low or mid read leaves the counter unchanged.
- R5: When an event strobe coincides with a high-word read of the same counter, the counter holds 1 afterwards.
- R6: Every counter stays at its all-ones value once it gets there, until it is cleared.
- R7: The receive-error-during-data count is read whole at address 12 and the receive-error-during-idle count at address 13.
- R8: Reading address 12 or 13 clears that 16-bit counter. A coincident event leaves it at 1.
- R9: Read data appears on rd_data at the clock edge after rd_en is sampled, and it holds until the next read.
- R10: Addresses 3, 7, 11, 14, 15 and 16 to 31 read as zero and change no counter.
- R11: When rst_n is low at a clock edge, all counters, all holding registers and rd_data become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_rx_ok | input | 1 | Error-free packet received strobe |
| ev_crc_bad | input | 1 | CRC error strobe |
| ev_tx_pkt | input | 1 | Packet transmitted strobe |
| ev_rxerr_data | input | 1 | Receive error during data strobe |
| ev_rxerr_idle | input | 1 | Receive error during idle strobe |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register address |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |

## Verification
Each read result is due on rd_data after the single register stage. The bench drives the read at one falling edge, and the monitor compares at the next falling edge, against an expected value that the driver queued in read order. Counter effects show up only through reads. The reference model therefore applies a read's snapshot or clear first and then the events of that same cycle, so the expected value and the next read's value match the edge at which the design updates. The hold property of rd_data is checked a full idle cycle after a read.

// File: rtl/link_stat_pkg.sv
// Package: shared constants, address decode types and decode function
// for the link statistics counter bank.
// Assumes a 5-bit register address space with the group in bits [3:2]
// and the word in bits [1:0].
package link_stat_pkg;

    localparam int ADDR_W      = 5;
    localparam int NUM_WIDE    = 3;
    localparam int WIDE_WORDS  = 3;
    localparam int NUM_NARROW  = 2;
    localparam int GRP_NARROW  = 3;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_WIDE   = 2'd1,
        SEL_NARROW = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e  kind;
        logic [1:0] grp;
        logic [1:0] word;
    } sel_t;

    // Map a register address onto a counter group and word.
    function automatic sel_t decode_addr(input logic [ADDR_W-1:0] a);
        sel_t s;
        s.kind = SEL_NONE;
        s.grp  = a[3:2];
        s.word = a[1:0];
        if (a[ADDR_W-1:4] == '0) begin
            if (int'(a[3:2]) < NUM_WIDE && int'(a[1:0]) < WIDE_WORDS)
                s.kind = SEL_WIDE;
            else if (int'(a[3:2]) == GRP_NARROW && int'(a[1:0]) < NUM_NARROW)
                s.kind = SEL_NARROW;
        end
        return s;
    endfunction

endpackage

// File: rtl/link_stat_wide_ctr.sv
// Wide saturating event counter, read as several words.
// A read of word 0 returns the live low word and latches the upper words
// into holding registers. A read of the last word returns its held value
// and clears the live count. A coincident event restarts the count at 1.
// Assumes rd_idx is valid whenever rd_en is high.
module link_stat_wide_ctr #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 3,
    localparam int TOT_W = WORD_W * WORDS,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    localparam logic [TOT_W-1:0] CNT_MAX  = '1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

    logic [TOT_W-1:0]  cnt;
    logic [WORD_W-1:0] hold [1:WORDS-1];
    logic              rd_first;
    logic              rd_last;

    assign rd_first = rd_en && (rd_idx == '0);
    assign rd_last  = rd_en && (rd_idx == IDX_LAST);

    // Live count: clear on last-word read, otherwise saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (rd_last)
            cnt <= evt ? TOT_W'(1) : '0;
        else if (evt && cnt != CNT_MAX)
            cnt <= cnt + TOT_W'(1);
    end

    // Holding registers: capture the upper words on a first-word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 1; k < WORDS; k++)
                hold[k] <= '0;
        end else if (rd_first) begin
            for (int k = 1; k < WORDS; k++)
                hold[k] <= cnt[k*WORD_W +: WORD_W];
        end
    end

    // Word select: live low word or a held upper word.
    always_comb begin
        rd_word = '0;
        if (rd_idx == '0)
            rd_word = cnt[WORD_W-1:0];
        for (int k = 1; k < WORDS; k++)
            if (rd_idx == IDX_W'(k))
                rd_word = hold[k];
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !rd_en && cnt != CNT_MAX) |=> cnt == $past(cnt) + TOT_W'(1));
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_first |=> $stable(hold[WORDS-1]));
    p_clear_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_last && !evt) |=> cnt == '0);
    p_restart_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_last && evt) |=> cnt == TOT_W'(1));
    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !rd_last) |=> cnt == CNT_MAX);

endmodule

// File: rtl/link_stat_narrow_ctr.sv
// Single-word saturating event counter that clears when it is read.
// An event in the reading cycle leaves the count at 1.
// Assumes the caller returns cnt as the read value in the reading cycle.
module link_stat_narrow_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         rd_en,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;

    // Count events, saturating, cleared on read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (rd_en)
            cnt <= evt ? W'(1) : '0;
        else if (evt && cnt != CNT_MAX)
            cnt <= cnt + W'(1);
    end

    p_narrow_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !evt) |=> cnt == '0);
    p_narrow_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && evt) |=> cnt == W'(1));
    p_narrow_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !rd_en) |=> cnt == CNT_MAX);

endmodule

// File: rtl/link_stat_bank.sv
// Link statistics counter bank: three wide packet/CRC counters read as
// low/mid/high words with snapshot and clear-on-read, two 16-bit error
// counters that clear on read, and a registered 16-bit read port.
// Assumes event strobes are synchronous to clk and one cycle wide.
module link_stat_bank
    import link_stat_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_ok,
    input  logic              ev_crc_bad,
    input  logic              ev_tx_pkt,
    input  logic              ev_rxerr_data,
    input  logic              ev_rxerr_idle,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int IDX_W = $clog2(WIDE_WORDS);

    logic [NUM_WIDE-1:0]   wide_evt;
    logic [NUM_NARROW-1:0] narrow_evt;
    logic [WORD_W-1:0]     wide_word  [NUM_WIDE];
    logic [WORD_W-1:0]     narrow_cnt [NUM_NARROW];
    logic [WORD_W-1:0]     sel_word;
    sel_t                  dec;

    assign wide_evt   = {ev_tx_pkt, ev_crc_bad, ev_rx_ok};
    assign narrow_evt = {ev_rxerr_idle, ev_rxerr_data};
    assign dec        = decode_addr(rd_addr);

    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
        logic rd_this;
        assign rd_this = rd_en && dec.kind == SEL_WIDE && dec.grp == 2'(g);
        link_stat_wide_ctr #(.WORD_W(WORD_W), .WORDS(WIDE_WORDS)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (wide_evt[g]),
            .rd_en   (rd_this),
            .rd_idx  (dec.word[IDX_W-1:0]),
            .rd_word (wide_word[g])
        );
    end

    for (genvar n = 0; n < NUM_NARROW; n++) begin : g_narrow
        logic rd_this;
        assign rd_this = rd_en && dec.kind == SEL_NARROW && dec.word == 2'(n);
        link_stat_narrow_ctr #(.W(WORD_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (narrow_evt[n]),
            .rd_en (rd_this),
            .cnt   (narrow_cnt[n])
        );
    end

    // Read mux: pick the addressed word, zero for unmapped addresses.
    always_comb begin
        sel_word = '0;
        case (dec.kind)
            SEL_WIDE: begin
                for (int g = 0; g < NUM_WIDE; g++)
                    if (dec.grp == 2'(g))
                        sel_word = wide_word[g];
            end
            SEL_NARROW: begin
                for (int n = 0; n < NUM_NARROW; n++)
                    if (dec.word == 2'(n))
                        sel_word = narrow_cnt[n];
            end
            default: sel_word = '0;
        endcase
    end

    // Read data register: loads on a read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= sel_word;
    end

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr[4] || rd_addr[1:0] == 2'd3 ||
                   (rd_addr[3:2] == 2'd3 && rd_addr[1]))) |=> rd_data == '0);
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);

endmodule

// File: tb/tb_link_stat_bank.sv
`timescale 1ns/1ps
module tb_link_stat_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_rx_ok = 1'b0, ev_crc_bad = 1'b0, ev_tx_pkt = 1'b0;
    logic        ev_rxerr_data = 1'b0, ev_rxerr_idle = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;

    logic [47:0] mw [3];
    logic [15:0] hm [3];
    logic [15:0] hh [3];
    logic [15:0] mn [2];

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic        rd_q = 1'b0;

    always #4 clk = ~clk;

    link_stat_bank dut (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_ok(ev_rx_ok), .ev_crc_bad(ev_crc_bad), .ev_tx_pkt(ev_tx_pkt),
        .ev_rxerr_data(ev_rxerr_data), .ev_rxerr_idle(ev_rxerr_idle),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 3; i++) begin mw[i] = '0; hm[i] = '0; hh[i] = '0; end
        for (int i = 0; i < 2; i++) mn[i] = '0;
    endtask

    // Driver: one cycle of events and an optional read; queues the expectation.
    task automatic step(input logic [4:0] ev, input logic rd, input logic [4:0] a,
                        input string tag);
        logic [15:0] e;
        e = '0;
        if (rd) begin
            if (a[4] == 1'b0 && a[3:2] != 2'd3 && a[1:0] != 2'd3) begin
                int g;
                g = int'(a[3:2]);
                case (a[1:0])
                    2'd0: begin e = mw[g][15:0]; hm[g] = mw[g][31:16]; hh[g] = mw[g][47:32]; end
                    2'd1: e = hm[g];
                    default: begin e = hh[g]; mw[g] = '0; end
                endcase
            end else if (a == 5'd12 || a == 5'd13) begin
                e = mn[a - 5'd12];
                mn[a - 5'd12] = '0;
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < 3; i++)
            if (ev[i] && mw[i] != 48'hFFFF_FFFF_FFFF) mw[i] = mw[i] + 48'd1;
        for (int i = 0; i < 2; i++)
            if (ev[3+i] && mn[i] != 16'hFFFF) mn[i] = mn[i] + 16'd1;
        {ev_rxerr_idle, ev_rxerr_data, ev_tx_pkt, ev_crc_bad, ev_rx_ok} = ev;
        rd_en   = rd;
        rd_addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        step(5'b0, 1'b1, a, tag);
    endtask

    task automatic do_reset();
        {ev_rxerr_idle, ev_rxerr_data, ev_tx_pkt, ev_crc_bad, ev_rx_ok} = '0;
        rd_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(rd_data, 16'h0, "R11 rd_data after reset");
        rst_n = 1'b1;
        model_clear();
    endtask

    // Monitor: compares each read result one cycle after its strobe.
    always @(posedge clk) rd_q <= rd_en && rst_n;
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard: actual=%h expected=none", rd_data);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data, e, t);
            end
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();

        // R10 / R11: everything reads zero after reset.
        for (int a = 0; a < 32; a++) rd(5'(a), "R11 zero after reset");

        // R1: mixed event patterns.
        step(5'b11111, 1'b0, 0, "");
        step(5'b00101, 1'b0, 0, "");
        step(5'b01010, 1'b0, 0, "");
        step(5'b10100, 1'b0, 0, "");
        step(5'b00111, 1'b0, 0, "");
        // R2 low live, R3 mid/high held, R4 cleared after high.
        rd(5'd0, "R1 R2 rx_ok low");
        step(5'b00001, 1'b0, 0, "");
        rd(5'd1, "R3 rx_ok mid");
        rd(5'd2, "R3 rx_ok high");
        rd(5'd0, "R4 rx_ok after clear");
        rd(5'd4, "R1 crc low");
        rd(5'd5, "R4 crc mid no clear");
        rd(5'd4, "R4 crc low unchanged by mid");
        rd(5'd6, "R4 crc high");
        rd(5'd4, "R4 crc cleared");
        rd(5'd8, "R1 tx low");
        rd(5'd10, "R4 tx high");
        // R7: narrow counters.
        rd(5'd12, "R7 rxerr data");
        rd(5'd13, "R7 rxerr idle");
        rd(5'd12, "R8 rxerr data cleared");

        // R3: carry into the mid word, snapshot held against later events.
        for (int i = 0; i < 65541; i++) step(5'b00100, 1'b0, 0, "");
        rd(5'd8, "R2 tx low after carry");
        step(5'b00100, 1'b0, 0, "");
        step(5'b00100, 1'b0, 0, "");
        rd(5'd9, "R3 tx mid latched");
        step(5'b00100, 1'b0, 0, "");
        rd(5'd10, "R3 tx high latched");
        rd(5'd8, "R4 tx low after clear");

        // R5: event coincides with the clearing high read.
        step(5'b00010, 1'b0, 0, "");
        step(5'b00010, 1'b1, 5'd6, "R5 crc high with event");
        rd(5'd4, "R5 crc restarts at one");
        // R2: event in the low-read cycle is not in the returned value.
        step(5'b00010, 1'b1, 5'd4, "R2 low excludes same-cycle event");
        rd(5'd4, "R2 event counted after low read");

        // R8: coincident event with a narrow read.
        step(5'b10000, 1'b0, 0, "");
        step(5'b10000, 1'b1, 5'd13, "R8 idle read with event");
        rd(5'd13, "R8 idle restarts at one");

        // R6: saturation of a 16-bit counter.
        for (int i = 0; i < 65540; i++) step(5'b01000, 1'b0, 0, "");
        rd(5'd12, "R6 data error saturated");

        // R10: unmapped addresses with live counts present.
        step(5'b11111, 1'b0, 0, "");
        rd(5'd3, "R10 addr 3");
        rd(5'd7, "R10 addr 7");
        rd(5'd11, "R10 addr 11");
        rd(5'd14, "R10 addr 14");
        rd(5'd15, "R10 addr 15");
        rd(5'd16, "R10 addr 16");
        rd(5'd31, "R10 addr 31");
        rd(5'd0, "R10 rx_ok untouched");

        // R9: data holds through idle cycles.
        step(5'b00000, 1'b0, 0, "");
        step(5'b00001, 1'b0, 0, "");
        check(rd_data, 16'd1, "R9 rd_data holds");

        // R11: reset clears the live count and the holding registers.
        step(5'b00001, 1'b0, 0, "");
        rd(5'd0, "R11 snapshot before reset");
        do_reset();
        rd(5'd1, "R11 held mid cleared");
        rd(5'd2, "R11 held high cleared");
        rd(5'd0, "R11 live cleared");
        step(5'b0, 1'b0, 0, "");
        step(5'b0, 1'b0, 0, "");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule